// File: doc/BRIEF.md
# Power-Management Function Address Decoder

This block is the register side of a power-management function on a PCI-style configuration bus. It holds two I/O windows that software can move: a 128-byte power-management window and a 16-byte SMBus window. Each window has a base address register and an enable bit, and the enable bits live in configuration bytes separate from the bases. Each I/O address presented with a strobe is matched against both windows. The block reports a registered hit for each window one cycle later.

The block also holds a small event register set. Four event sources (timer, global lock, power button, real-time clock) set sticky status bits, which software clears by writing ones. A system control interrupt (SCI) level is raised whenever an enabled status bit is set, and only while the interrupt-pin byte is non-zero. A timer-arm output tells an external counter when a timer interrupt may be scheduled. The SMBus engine and the timer counter sit outside this block.

Configuration access is one byte per cycle. A write takes effect at the clock edge. Read data is registered, so it appears one cycle after the address and reflects the state before that edge.

Top module: `pm_fn_decode`

## Requirements
- R1: After reset, bytes 0x48 and 0x90 read 0x01, and bytes 0x49, 0x91, 0x41, 0xD2, 0xE0 and 0xE2 read 0x00. Byte 0x3D reads the INTPIN_RST parameter (default 0x01). Neither window hits, and sci and tmr_arm are low.
- R2: In the power-management base (bytes 0x48/0x49, a 16-bit address), only address bits 15..7 are stored. Bit 0 of byte 0x48 always reads 1 and bits 6..1 read 0. Bytes 0x4A and 0x4B read 0. The base changes only on a configuration write.
- R3: The power-management window covers 128 addresses from its base. It hits only while bit 7 of byte 0x41 is set.
- R4: In the SMBus base (bytes 0x90/0x91), only address bits 15..4 are stored. Bit 0 of byte 0x90 always reads 1 and bits 3..1 read 0.
- R5: A write to byte 0xD2 stores only its low nibble, so the upper nibble reads 0. Bit 0 of 0xD2 enables the 16-byte SMBus window.
- R6: pm_hit and smb_hit are registered. Each is high for exactly the cycle after a cycle with io_strobe high and a matching, enabled window, and is low otherwise.
- R7: Status byte 0xE0 holds bit 0 timer, bit 1 global lock, bit 2 power button and bit 3 real-time clock. evt_set[i] sets bit i. Writing 1 to a bit of 0xE0 clears it, and writing 0 leaves it unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R8: Enable byte 0xE2 uses the same bit layout in its low nibble, and its upper nibble reads 0. sci is high when any status bit and its matching enable bit are both set. It follows changes in the cycle after the register edge, with no extra latency.
- R9: sci stays low whenever the interrupt-pin byte 0x3D is zero, whatever the status and enable bits are.
- R10: tmr_arm is high exactly when enable bit 0 is set and status bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data for the previous cycle's offset |
| io_strobe | input | 1 | I/O address valid |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Registered power-management window hit |
| smb_hit | output | 1 | Registered SMBus window hit |
| evt_set | input | 4 | Event set pulses: timer, global lock, power button, RTC |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Timer interrupt may be scheduled |

## Verification
The bench probes addresses just inside and just outside both ends of each window. A decoder that compares too many or too few address bits would show the wrong window size or alias. It writes all-ones to both base bytes and to 0xD2, which exposes a design that keeps masked bits or drops the forced bit 0. It clears and sets one status bit in the same cycle: a design where the clear wins would lose the event. It then zeroes the interrupt-pin byte while an enabled event is pending, which catches an SCI that ignores the pin gate. Finally, it toggles the enables and confirms that each window goes silent when disabled.

// File: rtl/pm_fn_pkg.sv
package pm_fn_pkg;
  localparam int IO_W = 16;
  localparam int EVT_N = 4;

  localparam logic [7:0] OFF_INTPIN  = 8'h3D;
  localparam logic [7:0] OFF_PM_CTL  = 8'h41;
  localparam logic [7:0] OFF_PM_LO   = 8'h48;
  localparam logic [7:0] OFF_PM_HI   = 8'h49;
  localparam logic [7:0] OFF_SMB_LO  = 8'h90;
  localparam logic [7:0] OFF_SMB_HI  = 8'h91;
  localparam logic [7:0] OFF_SMB_CTL = 8'hD2;
  localparam logic [7:0] OFF_EVT_STS = 8'hE0;
  localparam logic [7:0] OFF_EVT_EN  = 8'hE2;

  localparam int PM_EN_BIT  = 7;
  localparam int SMB_EN_BIT = 0;

  typedef enum logic [1:0] {
    EVT_TMR  = 2'd0,
    EVT_GLB  = 2'd1,
    EVT_PBTN = 2'd2,
    EVT_RTC  = 2'd3
  } evt_idx_e;
endpackage

// File: rtl/pm_fn_cfg.sv
module pm_fn_cfg
  import pm_fn_pkg::*;
#(
  parameter int         PM_LG      = 7,
  parameter int         SMB_LG     = 4,
  parameter logic [7:0] INTPIN_RST = 8'h01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [7:0]         cfg_addr,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [EVT_N-1:0]   sts_in,
  output logic [EVT_N-1:0]   sts_clr,
  output logic [EVT_N-1:0]   evt_en,
  output logic [7:0]         intpin,
  output logic [IO_W-1:0]    pm_base,
  output logic               pm_en,
  output logic [IO_W-1:0]    smb_base,
  output logic               smb_en
);
  localparam logic [7:0] PM_LO_MASK  = 8'hFF << PM_LG;
  localparam logic [7:0] SMB_LO_MASK = 8'hFF << SMB_LG;
  localparam logic [7:0] IO_SPACE    = 8'h01;

  logic [IO_W-1:0]  pm_base_q, smb_base_q;
  logic [7:0]       pm_ctl_q, smb_ctl_q, intpin_q;
  logic [EVT_N-1:0] en_q;
  logic [7:0]       rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_base_q  <= '0;
      smb_base_q <= '0;
      pm_ctl_q   <= '0;
      smb_ctl_q  <= '0;
      intpin_q   <= INTPIN_RST;
      en_q       <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        OFF_INTPIN:  intpin_q <= cfg_wdata;
        OFF_PM_CTL:  pm_ctl_q <= cfg_wdata;
        OFF_PM_LO:   pm_base_q[7:0]  <= cfg_wdata & PM_LO_MASK;
        OFF_PM_HI:   pm_base_q[15:8] <= cfg_wdata;
        OFF_SMB_LO:  smb_base_q[7:0]  <= cfg_wdata & SMB_LO_MASK;
        OFF_SMB_HI:  smb_base_q[15:8] <= cfg_wdata;
        OFF_SMB_CTL: smb_ctl_q <= {4'h0, cfg_wdata[3:0]};
        OFF_EVT_EN:  en_q <= cfg_wdata[EVT_N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      OFF_INTPIN:  rd_mux = intpin_q;
      OFF_PM_CTL:  rd_mux = pm_ctl_q;
      OFF_PM_LO:   rd_mux = pm_base_q[7:0] | IO_SPACE;
      OFF_PM_HI:   rd_mux = pm_base_q[15:8];
      OFF_SMB_LO:  rd_mux = smb_base_q[7:0] | IO_SPACE;
      OFF_SMB_HI:  rd_mux = smb_base_q[15:8];
      OFF_SMB_CTL: rd_mux = smb_ctl_q;
      OFF_EVT_STS: rd_mux = {{(8-EVT_N){1'b0}}, sts_in};
      OFF_EVT_EN:  rd_mux = {{(8-EVT_N){1'b0}}, en_q};
      default:     rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= 8'h00;
    else     cfg_rdata <= rd_mux;
  end

  assign sts_clr  = (cfg_wr && cfg_addr == OFF_EVT_STS) ? cfg_wdata[EVT_N-1:0] : '0;
  assign evt_en   = en_q;
  assign intpin   = intpin_q;
  assign pm_base  = pm_base_q;
  assign smb_base = smb_base_q;
  assign pm_en    = pm_ctl_q[PM_EN_BIT];
  assign smb_en   = smb_ctl_q[SMB_EN_BIT];
endmodule

// File: rtl/pm_fn_window.sv
module pm_fn_window
  import pm_fn_pkg::*;
#(
  parameter int LG = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [IO_W-1:0] addr,
  input  logic [IO_W-1:0] base,
  input  logic            en,
  output logic            hit
);
  localparam int TAG_W = IO_W - LG;

  logic [TAG_W-1:0] addr_tag, base_tag;
  assign addr_tag = addr[IO_W-1:LG];
  assign base_tag = base[IO_W-1:LG];

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= strobe && en && (addr_tag == base_tag);
  end
endmodule

// File: rtl/pm_fn_sci.sv
module pm_fn_sci
  import pm_fn_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_N-1:0] evt_set,
  input  logic [EVT_N-1:0] sts_clr,
  input  logic [EVT_N-1:0] evt_en,
  input  logic [7:0]       intpin,
  output logic [EVT_N-1:0] sts,
  output logic             sci,
  output logic             tmr_arm
);
  logic [EVT_N-1:0] sts_q;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= (sts_q & ~sts_clr) | evt_set;
  end

  logic pending;
  assign pending = |(sts_q & evt_en);
  assign sci     = pending && (intpin != 8'h00);
  assign tmr_arm = evt_en[EVT_TMR] && !sts_q[EVT_TMR];
  assign sts     = sts_q;
endmodule

// File: rtl/pm_fn_decode.sv
module pm_fn_decode
  import pm_fn_pkg::*;
#(
  parameter int         PM_LG      = 7,
  parameter int         SMB_LG     = 4,
  parameter logic [7:0] INTPIN_RST = 8'h01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        io_strobe,
  input  logic [15:0] io_addr,
  output logic        pm_hit,
  output logic        smb_hit,
  input  logic [3:0]  evt_set,
  output logic        sci,
  output logic        tmr_arm
);
  logic [EVT_N-1:0] sts_w, sts_clr_w, evt_en_w;
  logic [7:0]       intpin_w;
  logic [IO_W-1:0]  pm_base_w, smb_base_w;
  logic             pm_en_w, smb_en_w;

  pm_fn_cfg #(.PM_LG(PM_LG), .SMB_LG(SMB_LG), .INTPIN_RST(INTPIN_RST)) cfg_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sts_in(sts_w),
    .sts_clr(sts_clr_w), .evt_en(evt_en_w), .intpin(intpin_w),
    .pm_base(pm_base_w), .pm_en(pm_en_w), .smb_base(smb_base_w),
    .smb_en(smb_en_w)
  );

  pm_fn_window #(.LG(PM_LG)) pm_win_i (
    .clk(clk), .rst(rst), .strobe(io_strobe), .addr(io_addr),
    .base(pm_base_w), .en(pm_en_w), .hit(pm_hit)
  );

  pm_fn_window #(.LG(SMB_LG)) smb_win_i (
    .clk(clk), .rst(rst), .strobe(io_strobe), .addr(io_addr),
    .base(smb_base_w), .en(smb_en_w), .hit(smb_hit)
  );

  pm_fn_sci sci_i (
    .clk(clk), .rst(rst), .evt_set(evt_set), .sts_clr(sts_clr_w),
    .evt_en(evt_en_w), .intpin(intpin_w), .sts(sts_w), .sci(sci),
    .tmr_arm(tmr_arm)
  );
endmodule

// File: rtl/pm_fn_decode_chk.sv
module pm_fn_decode_chk
  import pm_fn_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic [7:0]       cfg_addr,
  input logic [7:0]       cfg_wdata,
  input logic             io_strobe,
  input logic             pm_hit,
  input logic             smb_hit,
  input logic             pm_en,
  input logic             smb_en,
  input logic [IO_W-1:0]  pm_base,
  input logic [EVT_N-1:0] evt_set,
  input logic [EVT_N-1:0] sts,
  input logic [EVT_N-1:0] evt_en,
  input logic             sci
);
  AST_PM_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    pm_hit |-> ($past(io_strobe) && $past(pm_en)));  // R3
  AST_SMB_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    smb_hit |-> ($past(io_strobe) && $past(smb_en)));  // R5
  AST_NO_HIT_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !io_strobe |=> (!pm_hit && !smb_hit));  // R6
  AST_PM_BASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(pm_base));  // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == OFF_EVT_STS) |=>
      ((sts & $past(cfg_wdata[EVT_N-1:0] & ~evt_set)) == '0));  // R7
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((sts & $past(evt_set)) == $past(evt_set)));  // R7
  AST_SCI_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    sci |-> ((sts & evt_en) != '0));  // R8
endmodule

bind pm_fn_decode pm_fn_decode_chk chk_i (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .io_strobe(io_strobe), .pm_hit(pm_hit),
  .smb_hit(smb_hit), .pm_en(pm_en_w), .smb_en(smb_en_w),
  .pm_base(pm_base_w), .evt_set(evt_set), .sts(sts_w),
  .evt_en(evt_en_w), .sci(sci)
);

// File: tb/pm_fn_decode_tb_top.sv
module pm_fn_decode_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
  logic io_strobe = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic pm_hit, smb_hit;
  logic [3:0] evt_set = 4'h0;
  logic sci, tmr_arm;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pm_fn_decode dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_strobe(io_strobe),
    .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit),
    .evt_set(evt_set), .sci(sci), .tmr_arm(tmr_arm)
  );

  // {address, expected pm_hit, expected smb_hit}; PM base 0x4000, SMB base 0x5010
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {16'h4000, 2'b10}, {16'h407F, 2'b10}, {16'h4040, 2'b10},
    {16'h4080, 2'b00}, {16'h3FFF, 2'b00}, {16'h5010, 2'b01},
    {16'h501F, 2'b01}, {16'h5020, 2'b00}, {16'h500F, 2'b00},
    {16'hC000, 2'b00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic io_probe(input logic [15:0] a, output logic [1:0] h);
    @(negedge clk);
    io_strobe = 1'b1; io_addr = a;
    @(negedge clk);
    io_strobe = 1'b0;
    h = {pm_hit, smb_hit};
  endtask

  task automatic pulse_evt(input logic [3:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [1:0] h;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    cfg_read(8'h48, d); check("R1 pm lo", d, 8'h01);
    cfg_read(8'h49, d); check("R1 pm hi", d, 8'h00);
    cfg_read(8'h90, d); check("R1 smb lo", d, 8'h01);
    cfg_read(8'h91, d); check("R1 smb hi", d, 8'h00);
    cfg_read(8'h41, d); check("R1 pm ctl", d, 8'h00);
    cfg_read(8'hD2, d); check("R1 smb ctl", d, 8'h00);
    cfg_read(8'hE0, d); check("R1 sts", d, 8'h00);
    cfg_read(8'hE2, d); check("R1 en", d, 8'h00);
    cfg_read(8'h3D, d); check("R1 intpin", d, 8'h01);
    check("R1 sci", {7'h0, sci}, 8'h00);
    check("R1 tmr_arm", {7'h0, tmr_arm}, 8'h00);
    io_probe(16'h0000, h); check("R1 no hit", {6'h0, h}, 8'h00);

    // R2 / R4 / R5 masking
    cfg_write(8'h48, 8'hFF); cfg_read(8'h48, d); check("R2 pm lo mask", d, 8'h81);
    cfg_write(8'h4A, 8'hFF); cfg_read(8'h4A, d); check("R2 pm upper byte", d, 8'h00);
    cfg_write(8'h90, 8'hFF); cfg_read(8'h90, d); check("R4 smb lo mask", d, 8'hF1);
    cfg_write(8'hD2, 8'hFF); cfg_read(8'hD2, d); check("R5 smb ctl nibble", d, 8'h0F);

    // window setup, then table walk (R3 R5 R6)
    cfg_write(8'h48, 8'h00); cfg_write(8'h49, 8'h40); cfg_write(8'h41, 8'h80);
    cfg_write(8'h90, 8'h10); cfg_write(8'h91, 8'h50); cfg_write(8'hD2, 8'h01);
    for (int i = 0; i < NV; i++) begin
      io_probe(VEC[i][17:2], h);
      check($sformatf("R3/R5 decode %h", VEC[i][17:2]), {6'h0, h}, {6'h0, VEC[i][1:0]});
    end

    // R6 hit lasts one cycle only
    io_probe(16'h4000, h); check("R6 hit", {6'h0, h}, 8'h02);
    @(negedge clk); check("R6 hit drops", {6'h0, pm_hit, smb_hit}, 8'h00);

    // R3 / R5 disable
    cfg_write(8'h41, 8'h7F); io_probe(16'h4000, h); check("R3 pm disabled", {6'h0, h}, 8'h00);
    cfg_write(8'hD2, 8'hFE); cfg_read(8'hD2, d); check("R5 ctl", d, 8'h0E);
    io_probe(16'h5010, h); check("R5 smb disabled", {6'h0, h}, 8'h00);

    // R8 / R7
    cfg_write(8'hE2, 8'hF4); cfg_read(8'hE2, d); check("R8 en nibble", d, 8'h04);
    pulse_evt(4'h4); check("R8 sci on", {7'h0, sci}, 8'h01);
    cfg_read(8'hE0, d); check("R7 sts set", d, 8'h04);
    cfg_write(8'hE0, 8'h00); cfg_read(8'hE0, d); check("R7 zero write keeps", d, 8'h04);
    cfg_write(8'hE0, 8'h04); check("R8 sci off", {7'h0, sci}, 8'h00);
    cfg_read(8'hE0, d); check("R7 w1c", d, 8'h00);
    pulse_evt(4'h8); check("R8 masked", {7'h0, sci}, 8'h00);
    cfg_write(8'hE2, 8'h08); check("R8 enable later", {7'h0, sci}, 8'h01);

    // R9 pin gating
    cfg_write(8'h3D, 8'h00); check("R9 gated", {7'h0, sci}, 8'h00);
    cfg_write(8'h3D, 8'h02); check("R9 ungated", {7'h0, sci}, 8'h01);

    // R7 set beats clear in same cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'hE0; cfg_wdata = 8'h08; evt_set = 4'h8;
    @(negedge clk);
    cfg_wr = 1'b0; evt_set = 4'h0;
    cfg_read(8'hE0, d); check("R7 set wins", d, 8'h08);
    cfg_write(8'hE0, 8'h0F);

    // R10 timer arm
    cfg_write(8'hE2, 8'h01); check("R10 armed", {7'h0, tmr_arm}, 8'h01);
    pulse_evt(4'h1); check("R10 disarmed", {7'h0, tmr_arm}, 8'h00);
    check("R8 timer sci", {7'h0, sci}, 8'h01);
    cfg_write(8'hE0, 8'h01); check("R10 rearmed", {7'h0, tmr_arm}, 8'h01);
    cfg_write(8'hE2, 8'h00); check("R10 no enable", {7'h0, tmr_arm}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule